// File: doc/BRIEF.md
# Second-Mark Pulse Burst Generator

This block turns a once-per-second timing mark into a low-rate clock whose average frequency is exact. Each time the mark rises, the block emits a counted train of 32768 pulses at a fixed rate a little above 32.768 kHz. It then stays quiet until the next mark. Over every second the pulse total is exact, so a counter or clock divider fed by the output keeps correct long-term time. The spacing of the pulses inside the second is deliberately uneven.

The raw mark first passes a two-flop synchronizer and a rising-edge detector. A three-state machine runs the burst. **IDLE** waits for an edge (transition *start*: IDLE to HIGH). **HIGH** holds the output high for one half period (transition *fall*: HIGH to LOW). **LOW** holds it low for one half period. From LOW, transition *again* goes back to HIGH when more pulses remain, and transition *finish* goes to IDLE after the last pulse. A mark that arrives while a burst is still running gives a one-cycle overrun strobe and is otherwise ignored. The running burst continues to its end.

The half period is counted in system clock cycles. With the defaults (2500 cycles at 200 MHz), the pulse rate is 40 kHz and a burst lasts about 0.82 s, which leaves margin before the next mark.

Top module: `pps_burst_gen`

## Requirements
- R1: Each rising edge of the synchronized mark that is seen in IDLE produces exactly BURST_COUNT (default 32768) rising edges on `pulse_o`, and no more.
- R2: Only a low-to-high change of `pps_i` starts a burst. Holding `pps_i` high does not start a second burst or raise `overrun_o`. The mark passes two synchronizer flops before it is used.
- R3: After the last pulse, `pulse_o` and `busy_o` stay low until the next qualifying mark edge.
- R4: Each pulse is high for exactly HALF_CYCLES clock cycles. Consecutive pulses in a burst are separated by exactly HALF_CYCLES low cycles, which gives a rate of f_clk / (2*HALF_CYCLES).
- R5: `busy_o` is high from the cycle the first pulse rises until the low phase after the last pulse ends. `pulse_o` is never high while `busy_o` is low.
- R6: A mark edge during a burst raises `overrun_o` for exactly one cycle. The current burst keeps its full count and no extra burst follows.
- R7: A synchronous reset (`rst_i` high at a clock edge) drives `pulse_o`, `busy_o` and `overrun_o` low and aborts any burst. No burst resumes after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pps_i | input | 1 | Raw once-per-second mark, asynchronous |
| pulse_o | output | 1 | Burst pulse output |
| busy_o | output | 1 | High while a burst is in progress |
| overrun_o | output | 1 | One-cycle strobe for a mark edge seen during a burst |

## Verification
The bench counts every pulse between one mark and the end of its burst against an expected total of 32768. A design with an off-by-one terminal count would give 32767 or 32769. A second mark edge is injected in the middle of a burst. A design that restarted or dropped the burst would show a wrong total or an extra busy period, and one that missed the overrun would show no strobe. The mark is also held high for thousands of cycles; a level-triggered start would show a second burst or an overrun. Finally, reset is applied in the middle of a burst, and a design that kept running would still show busy or pulses afterwards.

// File: rtl/pps_burst_pkg.sv
package pps_burst_pkg;

    // Burst sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a mark edge
        ST_HIGH = 2'd1,   // output pulse high phase
        ST_LOW  = 2'd2    // output pulse low phase
    } burst_state_t;

endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // synchronizer chain built stage by stage
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q[g] <= 1'b0;
                else       chain_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q[g] <= 1'b0;
                else       chain_q[g] <= chain_q[g-1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) last_q <= 1'b0;
        else       last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int HALF_CYCLES = 2500
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int TW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [TW-1:0] TERM = TW'(HALF_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == TERM);

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i || expire_o) cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pulse_tally.sv
module pulse_tally #(
    parameter int BURST_COUNT = 32768
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int CW = (BURST_COUNT > 1) ? $clog2(BURST_COUNT) : 1;
    localparam logic [CW-1:0] FINAL = CW'(BURST_COUNT - 1);

    logic [CW-1:0] cnt_q;

    assign last_o = (cnt_q == FINAL);

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) cnt_q <= '0;
        else if (step_i)      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pps_burst_gen.sv
module pps_burst_gen
    import pps_burst_pkg::*;
#(
    parameter int BURST_COUNT = 32768,
    parameter int HALF_CYCLES = 2500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pps_i,
    output logic pulse_o,
    output logic busy_o,
    output logic overrun_o
);
    burst_state_t state_q, state_d;
    logic pps_edge;
    logic phase_done;
    logic last_pulse;
    logic tally_clear;
    logic tally_step;

    pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (pps_i),
        .rise_o  (pps_edge)
    );

    phase_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_i    (state_q != ST_IDLE),
        .expire_o (phase_done)
    );

    assign tally_clear = (state_q == ST_IDLE);
    assign tally_step  = (state_q == ST_LOW) && phase_done;

    pulse_tally #(.BURST_COUNT(BURST_COUNT)) u_tally (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (tally_clear),
        .step_i  (tally_step),
        .last_o  (last_pulse)
    );

    // next-state logic: start, fall, again, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pps_edge)   state_d = ST_HIGH;
            ST_HIGH: if (phase_done) state_d = ST_LOW;
            ST_LOW:  if (phase_done) state_d = last_pulse ? ST_IDLE : ST_HIGH;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pulse_o   <= 1'b0;
            busy_o    <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            pulse_o   <= (state_d == ST_HIGH);
            busy_o    <= (state_d != ST_IDLE);
            overrun_o <= pps_edge && (state_q != ST_IDLE);
        end
    end
endmodule

// File: rtl/pps_burst_chk.sv
module pps_burst_chk #(
    parameter int BURST_COUNT = 32768,
    parameter int HALF_CYCLES = 2500
) (
    input logic clk_i,
    input logic rst_i,
    input logic pulse_o,
    input logic busy_o,
    input logic overrun_o,
    input logic pps_edge
);
    localparam int NW = $clog2(BURST_COUNT + 1) + 1;
    localparam int HW = $clog2(HALF_CYCLES + 1) + 1;

    logic          prev_pulse_q;
    logic [NW-1:0] rises_q;
    logic [HW-1:0] high_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_pulse_q <= 1'b0;
            rises_q      <= '0;
            high_q       <= '0;
        end else begin
            prev_pulse_q <= pulse_o;
            if (!busy_o)                     rises_q <= '0;
            else if (pulse_o && !prev_pulse_q) rises_q <= rises_q + 1'b1;
            if (pulse_o) high_q <= high_q + 1'b1;
            else         high_q <= '0;
        end
    end

    assert_burst_total_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> (rises_q == NW'(BURST_COUNT)));

    assert_start_needs_edge_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> $past(pps_edge));

    assert_quiet_after_burst_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> (!pulse_o && $past(!pulse_o)));

    assert_high_width_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pulse_o) |-> (high_q == HW'(HALF_CYCLES)));

    assert_pulse_within_busy_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> busy_o);

    assert_overrun_in_burst_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        overrun_o |-> $past(busy_o));

    assert_overrun_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        overrun_o |=> !overrun_o);
endmodule

bind pps_burst_gen pps_burst_chk #(
    .BURST_COUNT (BURST_COUNT),
    .HALF_CYCLES (HALF_CYCLES)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .pulse_o   (pulse_o),
    .busy_o    (busy_o),
    .overrun_o (overrun_o),
    .pps_edge  (pps_edge)
);

// File: tb/tb_pps_burst_gen.sv
`timescale 1ns/1ps
module tb_pps_burst_gen;
    localparam int BURST = 32768;
    localparam int HALF  = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pps = 1'b0;
    logic pulse, busy, overrun;

    int total = 0;
    int bad   = 0;
    int exp_q[$];
    int rises = 0, hi_len = 0, lo_len = 0, width_err = 0;
    int all_rises = 0, ovr_seen = 0, idle_err = 0, bursts_done = 0;
    logic prev_p = 1'b0, prev_b = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pps_burst_gen #(.BURST_COUNT(BURST), .HALF_CYCLES(HALF)) dut (
        .clk_i(clk), .rst_i(rst), .pps_i(pps),
        .pulse_o(pulse), .busy_o(busy), .overrun_o(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // driver: one mark, optionally pushing the expected burst total
    task automatic mark(input int high_cycles, input bit expect_burst);
        if (expect_burst) exp_q.push_back(BURST);
        pps = 1'b1;
        repeat (high_cycles) @(negedge clk);
        pps = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 80000 && busy; i++) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            rises = 0; hi_len = 0; lo_len = 0; width_err = 0;
            prev_p = 1'b0; prev_b = 1'b0;
        end else begin
            if (pulse && !prev_p) begin
                if (rises != 0 && lo_len != HALF) width_err++;
                rises++; all_rises++; lo_len = 0;
            end
            if (pulse) hi_len++;
            else begin
                if (prev_p && hi_len != HALF) width_err++;
                hi_len = 0; lo_len++;
            end
            if (pulse && !busy) idle_err++;
            if (overrun) ovr_seen++;
            if (!busy && prev_b) begin
                if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    chk(rises == e, "R1 pulses per burst", rises, e);
                end else begin
                    chk(1'b0, "R6 unexpected extra burst", rises, 0);
                end
                chk(width_err == 0, "R4 pulse/gap width errors", width_err, 0);
                bursts_done++;
                rises = 0; width_err = 0;
            end
            prev_p = pulse; prev_b = busy;
        end
    end

    initial begin
        int r0;
        repeat (4) @(negedge clk);
        chk(!pulse && !busy && !overrun, "R7 reset state", {pulse, busy, overrun}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // burst one with an overrun mark in the middle
        mark(4, 1'b1);
        repeat (10) @(negedge clk);
        chk(busy == 1'b1, "R5 busy during burst", busy, 1);
        repeat (20000) @(negedge clk);
        mark(4, 1'b0);
        repeat (10) @(negedge clk);
        chk(ovr_seen == 1, "R6 overrun strobe count", ovr_seen, 1);
        chk(busy == 1'b1, "R6 burst continues after overrun", busy, 1);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R1 burst one completed", exp_q.size(), 0);

        // quiet period
        r0 = all_rises;
        repeat (300) @(negedge clk);
        chk(all_rises == r0 && !busy, "R3 idle after burst", all_rises - r0, 0);

        // burst two: mark held high for a long time
        mark(3000, 1'b1);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(ovr_seen == 1, "R2 held level gives no overrun", ovr_seen, 1);
        chk(bursts_done == 2, "R2 held level gives one burst", bursts_done, 2);
        chk(exp_q.size() == 0, "R1 burst two completed", exp_q.size(), 0);

        // burst three aborted by reset
        mark(4, 1'b0);
        repeat (50) @(negedge clk);
        chk(busy == 1'b1, "R7 burst running before reset", busy, 1);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!pulse && !busy && !overrun, "R7 outputs low in reset", {pulse, busy, overrun}, 0);
        rst = 1'b0;
        r0 = all_rises;
        repeat (200) @(negedge clk);
        chk(!busy && all_rises == r0, "R7 no resume after reset", all_rises - r0, 0);
        chk(idle_err == 0, "R5 pulse seen without busy", idle_err, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule